// File: doc/BRIEF.md
# Watchdog Timer with Event Sources

This block is a byte-programmed watchdog. Software loads a timeout value. A down-counter then steps once for each timebase tick. When the counter expires, a sticky status flag is set, and one interrupt line chosen by a mapping field stays asserted until software clears the flag. Keyboard and mouse interrupt pulses can each restart the count when their enable is set. This lets ordinary input activity keep the watchdog from firing.

A timeout can also be forced in two ways. The first is a self-clearing write bit. The second is the rising edge of a keyboard-controller output pin, when that source is enabled. The pin passes through a synchronizer and a level-aware edge detector. The detector gives exactly one pulse per qualifying edge, and it counts the enabling write itself as an edge when the pin is already high. There are two resets. The power-on reset clears everything. The bus reset clears the configuration, the timeout value and the counter, but it leaves the status flag unchanged.

Top module: `wdt_event_timer`

## Requirements
- R1: After power-on reset every register reads 0x00 and all of `irq_out` is 0.
- R2: Register addresses are 0 for the timeout value (all 8 bits), 1 for configuration and 2 for control. Address 3 reads 0x00. Configuration bits 0 and 3 read 0. Control bits 1, 2 and 7:4 read 0.
- R3: Writing a nonzero value N to the timeout register loads the counter with N. After exactly N further tick pulses, status (control bit 0) reads 1, and after N-1 ticks it still reads 0. Writing 0 stops the counter, and no tick then produces a timeout.
- R4: When configuration bit 1 is 1, a keyboard interrupt pulse reloads the counter from the timeout register. When bit 1 is 0, keyboard pulses have no effect on the count.
- R5: Configuration bit 2 enables reload by mouse interrupt pulses in the same way. When bit 2 is 0, mouse pulses are ignored.
- R6: Configuration bits 7:4 hold a value k. When k is nonzero and status is 1, `irq_out[k]` is 1 and all other bits are 0. When k is 0 or status is 0, `irq_out` is all zero. `irq_out[0]` is never driven high.
- R7: Software writes status through control bit 0. A write of 0 clears it. A timeout event in the same cycle as the write takes priority and leaves status at 1.
- R8: Writing 1 to control bit 2 forces a timeout, which sets status on the next clock. The bit always reads 0. The forced timeout works whatever the value of control bit 3.
- R9: When control bit 3 is 1, a rising edge on `kbc_pin` forces a timeout within 4 clocks. When bit 3 is 0, pin edges are ignored.
- R10: If `kbc_pin` is already high when control bit 3 is set, a timeout is forced at once. A pin held high produces only one timeout per qualifying edge.
- R11: While `bus_rst_n` is low, the configuration register, control bit 3, the timeout value and the counter clear, and status keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous; keeps status |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Timebase pulse, one clock wide |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| kbc_pin | input | 1 | Asynchronous keyboard-controller output pin |
| irq_out | output | 16 | Interrupt lines; bit k is line k |

## Verification
A table of timeout values and tick counts checks the count boundary. Running one tick short of the value must leave status clear, and the full count must set it. This separates an off-by-one counter from a correct one. A zero value must never fire, a value of 1 must fire on the first tick, and a large value checks that the counter does not fire early. Reload is tried with each source both enabled and disabled. The disabled case must fire exactly where no reload happened, and the enabled case must fire only after the restarted count. The pin is driven as a plain edge, as a level already high when the source is enabled, and as a level held high after status is cleared. These three cases separate a true edge detector from a level detector and from one that misses the enable transition.

// File: rtl/wdt_pkg.sv
// Shared constants for the watchdog: register addresses and field positions.
// Assumes a byte-wide register bus with a 2-bit address.
package wdt_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int IRQ_LINES  = 16;
    localparam int MAP_W      = $clog2(IRQ_LINES);

    localparam logic [ADDR_W-1:0] A_TVAL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    localparam int CFG_KBD     = 1;
    localparam int CFG_MOUSE   = 2;
    localparam int CFG_MAP_LSB = 4;
    localparam logic [DATA_W-1:0] CFG_MASK = 8'hF6;

    localparam int CTRL_STAT  = 0;
    localparam int CTRL_FORCE = 2;
    localparam int CTRL_PINEN = 3;
endpackage

// File: rtl/wdt_regs.sv
// Register file: timeout value, configuration and control with sticky status.
// Assumes synchronous active-low resets; bus reset blocks writes and keeps status.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              timeout_evt,
    output logic              status,
    output logic              kbd_en,
    output logic              mouse_en,
    output logic [MAP_W-1:0]  irq_map,
    output logic              pin_en,
    output logic              force_wr,
    output logic [DATA_W-1:0] tval,
    output logic              tval_wr
);
    logic [DATA_W-1:0] cfg_q;
    logic              ctrl_wr;
    logic              cfg_wr;

    // Decode write strobes; writes are blocked during bus reset.
    always_comb begin
        tval_wr  = we && bus_rst_n && (addr == A_TVAL);
        cfg_wr   = we && bus_rst_n && (addr == A_CFG);
        ctrl_wr  = we && bus_rst_n && (addr == A_CTRL);
        force_wr = ctrl_wr && wdata[CTRL_FORCE];
    end

    // Configuration, pin enable and timeout value; cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rst_n) begin
            cfg_q  <= '0;
            pin_en <= 1'b0;
            tval   <= '0;
        end else begin
            if (cfg_wr)  cfg_q  <= wdata & CFG_MASK;
            if (ctrl_wr) pin_en <= wdata[CTRL_PINEN];
            if (tval_wr) tval   <= wdata;
        end
    end

    // Sticky status: cleared only by power-on reset; events win over writes.
    always_ff @(posedge clk) begin
        if (!rst_n)           status <= 1'b0;
        else if (timeout_evt) status <= 1'b1;
        else if (ctrl_wr)     status <= wdata[CTRL_STAT];
    end

    // Field extraction from the configuration byte.
    always_comb begin
        kbd_en   = cfg_q[CFG_KBD];
        mouse_en = cfg_q[CFG_MOUSE];
        irq_map  = cfg_q[CFG_MAP_LSB +: MAP_W];
    end

    // Read multiplexer; the force bit and reserved bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_TVAL: rdata = tval;
            A_CFG:  rdata = cfg_q;
            A_CTRL: begin
                rdata[CTRL_STAT]  = status;
                rdata[CTRL_PINEN] = pin_en;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
// Down-counter: loads on a value write or a reload, steps on tick, flags expiry.
// Assumes tick is one clock wide; a count of zero means stopped.
module wdt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    // Expiry when the last tick arrives with no competing load.
    always_comb begin
        expire = bus_rst_n && tick && (cnt == ONE) && !load && !reload;
    end

    // Count register: load beats reload beats tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rst_n)   cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (reload)            cnt <= reload_val;
        else if (tick && cnt != '0) cnt <= cnt - ONE;
    end
endmodule

// File: rtl/wdt_pin_edge.sv
// Synchronizes the pin and emits a one-cycle pulse per qualifying rising edge.
// Assumes an asynchronous pin; gating by enable makes enable-while-high an edge.
module wdt_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   armed_q;
    logic                   qual;

    // Synchronizer chain, one stage per generate step.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)     sync_q[s] <= 1'b0;
                else if (s == 0) sync_q[s] <= pin;
                else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Enable-gated level, whose rising edge is the qualifying event.
    always_comb qual = sync_q[SYNC_STAGES-1] && en;

    // Remember the gated level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= qual;
    end

    // Single pulse on a 0-to-1 change of the gated level.
    always_comb pulse = qual && !armed_q;
endmodule

// File: rtl/wdt_irq_map.sv
// Decodes the mapping field into interrupt lines, held while status is set.
// Assumes line 0 means disabled and is never driven.
module wdt_irq_map #(
    parameter int LINES = 16,
    localparam int MW   = $clog2(LINES)
) (
    input  logic [MW-1:0]    sel,
    input  logic             status,
    output logic [LINES-1:0] lines
);
    // One comparator per line; line 0 tied low.
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            if (i == 0) begin : g_off
                assign lines[i] = 1'b0;
            end else begin : g_on
                localparam logic [MW-1:0] IDX = MW'(i);
                assign lines[i] = status && (sel == IDX);
            end
        end
    endgenerate
endmodule

// File: rtl/wdt_event_timer.sv
// Top: watchdog with keyboard/mouse reload, forced timeout by write or pin edge.
// Assumes one clock domain; kbc_pin is asynchronous and synchronized inside.
module wdt_event_timer
    import wdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 tick,
    input  logic                 kbd_irq,
    input  logic                 mouse_irq,
    input  logic                 kbc_pin,
    output logic [IRQ_LINES-1:0] irq_out
);
    logic              status, kbd_en, mouse_en, pin_en;
    logic              force_wr, tval_wr, reload, expire, pin_pulse, timeout_evt;
    logic [MAP_W-1:0]  irq_map;
    logic [DATA_W-1:0] tval, cnt;

    // Combine reload sources and timeout sources.
    always_comb begin
        reload      = (kbd_irq && kbd_en) || (mouse_irq && mouse_en);
        timeout_evt = expire || force_wr || pin_pulse;
    end

    wdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .timeout_evt(timeout_evt), .status(status), .kbd_en(kbd_en),
        .mouse_en(mouse_en), .irq_map(irq_map), .pin_en(pin_en),
        .force_wr(force_wr), .tval(tval), .tval_wr(tval_wr)
    );

    wdt_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .tick(tick),
        .load(tval_wr), .load_val(reg_wdata), .reload(reload),
        .reload_val(tval), .cnt(cnt), .expire(expire)
    );

    wdt_pin_edge #(.SYNC_STAGES(2)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin(kbc_pin), .en(pin_en), .pulse(pin_pulse)
    );

    wdt_irq_map #(.LINES(IRQ_LINES)) u_irq (
        .sel(irq_map), .status(status), .lines(irq_out)
    );
endmodule

// File: rtl/wdt_event_timer_chk.sv
// Checker bound to the top: timing properties of count, status, pin and IRQs.
// Assumes it sees the top's internal nets by the same names.
module wdt_event_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rst_n,
    input logic        tick,
    input logic        reload,
    input logic        tval_wr,
    input logic        force_wr,
    input logic        timeout_evt,
    input logic        pin_pulse,
    input logic        status,
    input logic [7:0]  cnt,
    input logic [15:0] irq_out
);
    // R6: at most one line, and only while status is set.
    assert_irq_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out) && (irq_out == 16'd0 || status) && !irq_out[0]);

    // R3: counter steps down by one on a plain tick.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && tick && cnt > 8'd1 && !tval_wr && !reload)
        |=> (cnt == $past(cnt) - 8'd1));

    // R3: last tick sets status.
    assert_expire_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && tick && cnt == 8'd1 && !tval_wr && !reload) |=> status);

    // R8: forced write sets status.
    assert_force_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> status);

    // R10: pin pulse lasts one cycle.
    assert_pin_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pulse |=> !pin_pulse);

    // R11: bus reset keeps status absent an event.
    assert_bus_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rst_n && !timeout_evt) |=> (status == $past(status)));

    // R11: counter cleared by bus reset.
    assert_bus_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (cnt == 8'd0));
endmodule

bind wdt_event_timer wdt_event_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .tick(tick),
    .reload(reload), .tval_wr(tval_wr), .force_wr(force_wr),
    .timeout_evt(timeout_evt), .pin_pulse(pin_pulse), .status(status),
    .cnt(cnt), .irq_out(irq_out)
);

// File: tb/wdt_event_timer_test.sv
module wdt_event_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst_n = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        tick = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0, kbc_pin = 1'b0;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    wdt_event_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick(tick), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
        .kbc_pin(kbc_pin), .irq_out(irq_out)
    );

    // Table: timeout value, tick count, expected status (R3).
    localparam logic [23:0] VEC [0:5] = '{
        {8'd5,   8'd4,   8'd0},
        {8'd5,   8'd5,   8'd1},
        {8'd1,   8'd1,   8'd1},
        {8'd0,   8'd20,  8'd0},
        {8'd200, 8'd199, 8'd0},
        {8'd200, 8'd200, 8'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_kbd();
        @(negedge clk); kbd_irq = 1'b1;
        @(negedge clk); kbd_irq = 1'b0;
    endtask

    task automatic pulse_mouse();
        @(negedge clk); mouse_irq = 1'b1;
        @(negedge clk); mouse_irq = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: bench timed out");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        rd(2'd0, rv); check("R1 tval", rv, 8'h00);
        rd(2'd1, rv); check("R1 cfg", rv, 8'h00);
        rd(2'd2, rv); check("R1 ctrl", rv, 8'h00);
        check("R1 irq", irq_out, 16'h0);

        // R2: address map and reserved bits
        wr(2'd1, 8'hFF); rd(2'd1, rv); check("R2 cfg reserved", rv, 8'hF6);
        rd(2'd3, rv); check("R2 addr3", rv, 8'h00);
        wr(2'd0, 8'hA5); rd(2'd0, rv); check("R2 tval rw", rv, 8'hA5);
        wr(2'd2, 8'hFA); rd(2'd2, rv); check("R2 ctrl reserved", rv, 8'h08);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);

        // R3: table of counts
        for (int v = 0; v < 6; v++) begin
            wr(2'd2, 8'h00);
            wr(2'd0, VEC[v][23:16]);
            ticks(int'(VEC[v][15:8]));
            rd(2'd2, rv);
            check($sformatf("R3 vec%0d", v), rv[0], VEC[v][0]);
        end

        // R4: keyboard reload enabled
        wr(2'd2, 8'h00); wr(2'd1, 8'h02); wr(2'd0, 8'd4);
        ticks(3); pulse_kbd(); ticks(3);
        rd(2'd2, rv); check("R4 kbd reload holds", rv[0], 1'b0);
        ticks(1); rd(2'd2, rv); check("R4 kbd reload expires", rv[0], 1'b1);
        // R4: keyboard disabled
        wr(2'd2, 8'h00); wr(2'd1, 8'h04); wr(2'd0, 8'd4);
        ticks(3); pulse_kbd(); ticks(1);
        rd(2'd2, rv); check("R4 kbd ignored", rv[0], 1'b1);

        // R5: mouse reload enabled (bit 2 set from above)
        wr(2'd2, 8'h00); wr(2'd0, 8'd4);
        ticks(3); pulse_mouse(); ticks(3);
        rd(2'd2, rv); check("R5 mouse reload holds", rv[0], 1'b0);
        // R5: mouse disabled
        wr(2'd2, 8'h00); wr(2'd1, 8'h02); wr(2'd0, 8'd4);
        ticks(3); pulse_mouse(); ticks(1);
        rd(2'd2, rv); check("R5 mouse ignored", rv[0], 1'b1);

        // R8: forced timeout, bit reads 0; R7: event beats write of 0
        wr(2'd0, 8'd0); wr(2'd2, 8'h00);
        rd(2'd2, rv); check("R7 clear", rv[0], 1'b0);
        wr(2'd2, 8'h04);
        rd(2'd2, rv); check("R8 R7 force sets, reads 0", rv, 8'h01);

        // R6: mapping
        wr(2'd1, 8'h50); idle(1); check("R6 irq5", irq_out, 16'h0020);
        wr(2'd1, 8'hF0); idle(1); check("R6 irq15", irq_out, 16'h8000);
        wr(2'd1, 8'h00); idle(1); check("R6 disabled", irq_out, 16'h0000);
        wr(2'd1, 8'h30); wr(2'd2, 8'h00); idle(1); check("R6 status low", irq_out, 16'h0000);

        // R9: pin edge ignored while disabled
        kbc_pin = 1'b1; idle(5);
        rd(2'd2, rv); check("R9 pin disabled", rv[0], 1'b0);
        kbc_pin = 1'b0; idle(4);
        // R9: edge with enable
        wr(2'd2, 8'h08); idle(2);
        kbc_pin = 1'b1; idle(4);
        rd(2'd2, rv); check("R9 pin edge", rv[0], 1'b1);
        // R10: held high, no repeat after clear
        wr(2'd2, 8'h08); idle(6);
        rd(2'd2, rv); check("R10 no repeat", rv[0], 1'b0);
        // R10: enable while pin high
        wr(2'd2, 8'h00); idle(2);
        wr(2'd2, 8'h08); idle(2);
        rd(2'd2, rv); check("R10 enable while high", rv[0], 1'b1);
        // R8: write force with pin source enabled still works
        wr(2'd2, 8'h08); idle(2); wr(2'd2, 8'h0C);
        rd(2'd2, rv); check("R8 force with pin en", rv, 8'h09);
        kbc_pin = 1'b0; idle(3);

        // R11: bus reset keeps status, clears the rest
        wr(2'd1, 8'h56); wr(2'd0, 8'd9);
        @(negedge clk); bus_rst_n = 1'b0;
        @(negedge clk); bus_rst_n = 1'b1;
        rd(2'd1, rv); check("R11 cfg cleared", rv, 8'h00);
        rd(2'd0, rv); check("R11 tval cleared", rv, 8'h00);
        rd(2'd2, rv); check("R11 status kept", rv, 8'h01);
        wr(2'd2, 8'h00); ticks(12);
        rd(2'd2, rv); check("R11 counter stopped", rv[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule